// File: doc/BRIEF.md
# Multi-channel Byte-wise CRC16 Engine

This block keeps a running 16-bit CRC for each channel of an interleaved byte stream. The stream is typically taken from time-division slots. On any clock a new byte can arrive, tagged with its channel number. The engine fetches that channel's current CRC from an internal state array and advances it by one byte with a single-cycle combinational step. It then stores the result back, so the same channel can take another byte on the very next clock.

The byte step is a four-level shift-and-XOR network that matches the reflected CCITT polynomial (x^16 + x^12 + x^5 + 1, bits taken least significant first). In software terms: t = crc[7:0] ^ byte, then t = (t ^ (t << 4)) & 0xFF, then next = (crc >> 8) ^ (t << 8) ^ (t << 3) ^ (t >> 4). The network has no final inversion.

A separate strobe reseeds any channel to 0xFFFF. This is used at the start of a frame. A read port returns any channel's stored CRC one cycle after the request.

Top module: `crc16_mc_engine`

## Requirements
- R1: While reset is low, and after it is released, every channel holds 0xFFFF, and rd_valid and rd_crc are 0.
- R2: A byte accepted with upd_valid replaces the channel's CRC c with next(c, byte) as defined by the shift-and-XOR step, in the clock edge that samples it.
- R3: Starting from 0xFFFF, feeding the ASCII bytes 0x31 to 0x39 in order gives 0x6F91.
- R4: An update changes only the addressed channel; all other channels keep their values.
- R5: An init_valid strobe loads 0xFFFF into init_chan at the sampling edge.
- R6: When init and update target the same channel in the same cycle, the channel ends at 0xFFFF.
- R7: When init and update target different channels in the same cycle, both take effect.
- R8: rd_valid is high exactly one cycle after rd_req. rd_crc then shows the channel value held just before the request's edge, so an update in the same cycle is not yet visible.
- R9: Without a read request, rd_valid is low in the next cycle and rd_crc keeps its previous value.
- R10: Updates to one channel on consecutive cycles chain, each starting from the previous result.
- R11: With upd_valid low, upd_chan and upd_byte have no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | A byte is present this cycle |
| upd_chan | input | 6 | Channel of the byte |
| upd_byte | input | 8 | Data byte |
| init_valid | input | 1 | Reseed a channel to 0xFFFF |
| init_chan | input | 6 | Channel to reseed |
| rd_req | input | 1 | Request a CRC read-back |
| rd_chan | input | 6 | Channel to read |
| rd_valid | output | 1 | Read data present |
| rd_crc | output | 16 | CRC of the requested channel |

## Verification
The assertions assume that the inputs hold no unknown values once reset is released. They also assume that, in the cycle after an init of a channel, no other write can reach that channel before a read of it returns. Both hold by construction of the edge timing.

The bench meets these assumptions in two ways. It drives every input to a defined value at each falling edge. Its init-then-read sequences are placed so that a following read sees the reseed.

The step is compared against a bit-serial model of the same polynomial. This model shares no structure with the XOR network.

// File: rtl/crc16_mc_pkg.sv
// Package: shared types and constants for the multi-channel CRC16 engine.
// Assumes a 16-bit CRC updated eight bits at a time.
package crc16_mc_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam crc_t CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/crc16_byte_step.sv
// Module: crc16_byte_step
// Advances a reflected CCITT CRC16 by one byte, purely combinationally.
// The logic is about four XOR levels deep. Assumes the input CRC and byte
// are stable within the cycle. Holds no state.
module crc16_byte_step
    import crc16_mc_pkg::*;
(
    input  crc_t  crc_in,
    input  byte_t data_in,
    output crc_t  crc_out
);
    byte_t t_mix;
    byte_t t_fold;

    // Purpose: compute the folded byte and combine the shifted copies.
    always_comb begin
        t_mix   = crc_in[7:0] ^ data_in;
        t_fold  = t_mix ^ {t_mix[3:0], 4'b0000};
        crc_out = {8'h00, crc_in[15:8]}
                ^ {t_fold, 8'h00}
                ^ {5'b00000, t_fold, 3'b000}
                ^ {12'h000, t_fold[7:4]};
    end
endmodule

// File: rtl/crc16_chan_store.sv
// Module: crc16_chan_store
// Per-channel CRC state. It has one write port for updates, one reseed port
// and two combinational lookup ports: one for the update path, one for
// read-back. A reseed wins over an update to the same channel. Assumes
// NUM_CH <= 2**CH_W.
module crc16_chan_store
    import crc16_mc_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seed_en,
    input  logic [CH_W-1:0] seed_ch,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  crc_t            wr_data,
    input  logic [CH_W-1:0] lk_ch,
    output crc_t            lk_data,
    input  logic [CH_W-1:0] rd_ch,
    output crc_t            rd_data
);
    crc_t mem [NUM_CH];

    // Purpose: reset, reseed or update each entry with reseed priority.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n)
                mem[i] <= CRC_SEED;
            else if (seed_en && seed_ch == CH_W'(i))
                mem[i] <= CRC_SEED;
            else if (wr_en && wr_ch == CH_W'(i))
                mem[i] <= wr_data;
        end
    end

    // Purpose: combinational lookups for the update path and the read port.
    always_comb begin
        lk_data = mem[lk_ch];
        rd_data = mem[rd_ch];
    end
endmodule

// File: rtl/crc16_rd_port.sv
// Module: crc16_rd_port
// Registers the looked-up CRC when a read is requested. The result is valid
// one cycle later and held until the next request.
module crc16_rd_port
    import crc16_mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  crc_t data_in,
    output logic valid,
    output crc_t data_out
);
    // Purpose: capture the read data and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            data_out <= '0;
        end else begin
            valid <= req;
            if (req)
                data_out <= data_in;
        end
    end
endmodule

// File: rtl/crc16_mc_engine.sv
// Module: crc16_mc_engine (top)
// Interleaved multi-channel CRC16: one byte per clock for any channel, with
// per-channel reseed and a registered read-back. Assumes inputs are
// synchronous to clk.
module crc16_mc_engine
    import crc16_mc_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic [CH_W-1:0] upd_chan,
    input  logic [7:0]      upd_byte,
    input  logic            init_valid,
    input  logic [CH_W-1:0] init_chan,
    input  logic            rd_req,
    input  logic [CH_W-1:0] rd_chan,
    output logic            rd_valid,
    output logic [15:0]     rd_crc
);
    crc_t cur_crc;
    crc_t nxt_crc;
    crc_t rd_lookup;

    crc16_chan_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_en (init_valid),
        .seed_ch (init_chan),
        .wr_en   (upd_valid),
        .wr_ch   (upd_chan),
        .wr_data (nxt_crc),
        .lk_ch   (upd_chan),
        .lk_data (cur_crc),
        .rd_ch   (rd_chan),
        .rd_data (rd_lookup)
    );

    crc16_byte_step u_step (
        .crc_in  (cur_crc),
        .data_in (upd_byte),
        .crc_out (nxt_crc)
    );

    crc16_rd_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .data_in  (rd_lookup),
        .valid    (rd_valid),
        .data_out (rd_crc)
    );
endmodule

// File: rtl/crc16_mc_engine_chk.sv
// Module: crc16_mc_engine_chk
// Assertion checker bound to crc16_mc_engine. It watches the ports and the
// step inputs and outputs.
module crc16_mc_engine_chk #(
    parameter int CH_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            upd_valid,
    input logic [CH_W-1:0] upd_chan,
    input logic            init_valid,
    input logic [CH_W-1:0] init_chan,
    input logic            rd_req,
    input logic [CH_W-1:0] rd_chan,
    input logic            rd_valid,
    input logic [15:0]     rd_crc,
    input logic [15:0]     step_crc,
    input logic [7:0]      step_byte,
    input logic [15:0]     step_next
);
    // Purpose: bit-serial reference of the reflected polynomial.
    function automatic logic [15:0] serial_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++)
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    a_r2_step_matches_serial: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> step_next == serial_crc(step_crc, step_byte));

    a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && $stable(rd_crc)));

    a_r5_init_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_valid) && rd_req && rd_chan == $past(init_chan))
        |=> rd_crc == 16'hFFFF);

    a_r6_init_beats_update: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(init_valid && upd_valid && init_chan == upd_chan)
         && rd_req && rd_chan == $past(init_chan))
        |=> rd_crc == 16'hFFFF);
endmodule

bind crc16_mc_engine crc16_mc_engine_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_chan   (upd_chan),
    .init_valid (init_valid),
    .init_chan  (init_chan),
    .rd_req     (rd_req),
    .rd_chan    (rd_chan),
    .rd_valid   (rd_valid),
    .rd_crc     (rd_crc),
    .step_crc   (cur_crc),
    .step_byte  (upd_byte),
    .step_next  (nxt_crc)
);

// File: tb/crc16_mc_engine_test.sv
module crc16_mc_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_valid = 1'b0;
    logic [5:0] upd_chan = '0;
    logic [7:0] upd_byte = '0;
    logic       init_valid = 1'b0;
    logic [5:0] init_chan = '0;
    logic       rd_req = 1'b0;
    logic [5:0] rd_chan = '0;
    logic       rd_valid;
    logic [15:0] rd_crc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model [NCH];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] last_crc = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc16_mc_engine uut (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_byte(upd_byte),
        .init_valid(init_valid), .init_chan(init_chan),
        .rd_req(rd_req), .rd_chan(rd_chan),
        .rd_valid(rd_valid), .rd_crc(rd_crc)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++)
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; pushes expected read data and updates the model.
    task automatic drive(input bit uv, input logic [5:0] uc, input logic [7:0] ub,
                         input bit iv, input logic [5:0] ic,
                         input bit rv, input logic [5:0] rc,
                         input string tag, input bit force_exp = 1'b0,
                         input logic [15:0] fexp = '0);
        @(negedge clk);
        upd_valid = uv; upd_chan = uc; upd_byte = ub;
        init_valid = iv; init_chan = ic;
        rd_req = rv; rd_chan = rc;
        if (rv) begin
            exp_q.push_back(force_exp ? fexp : model[rc]);
            tag_q.push_back(tag);
        end
        if (uv && !(iv && ic == uc)) model[uc] = ref_crc(model[uc], ub);
        if (iv) model[ic] = 16'hFFFF;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, "");
    endtask

    // Monitor: compare read results with the scoreboard, and check the hold behaviour.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected rd_valid", rd_crc, 16'h0000);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_crc === e, t, rd_crc, e);
                end
            end else begin
                check(rd_crc === last_crc, "R9 rd_crc hold", rd_crc, last_crc);
            end
            last_crc = rd_crc;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check(rd_valid === 1'b0, "R1 rd_valid in reset", {15'b0, rd_valid}, 16'h0);
        check(rd_crc === 16'h0, "R1 rd_crc in reset", rd_crc, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every channel seeded after reset
        for (int i = 0; i < NCH; i++) drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'(i), "R1 seed", 1'b1, 16'hFFFF);

        // R3 / R10: known string on channel 5, back to back
        for (int i = 0; i < 9; i++) drive(1'b1, 6'd5, 8'h31 + 8'(i), 1'b0, '0, 1'b0, '0, "");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd5, "R3 check value", 1'b1, 16'h6F91);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd6, "R4 neighbour untouched", 1'b1, 16'hFFFF);

        // R2 / R4 / R8: random interleaved traffic with random reads
        for (int i = 0; i < 400; i++) begin
            rng = next_rng(rng);
            drive(rng[0], rng[6:1], rng[14:7], 1'b0, '0, rng[15], rng[21:16], "R2 R4 interleaved");
        end
        for (int i = 0; i < NCH; i++) drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'(i), "R4 sweep");

        // R10: same channel, many consecutive bytes
        for (int i = 0; i < 20; i++) drive(1'b1, 6'd40, 8'(i * 7 + 3), 1'b0, '0, 1'b0, '0, "");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd40, "R10 chained");

        // R11: upd_valid low with busy channel and byte
        for (int i = 0; i < 16; i++) drive(1'b0, 6'(i), 8'hA5 ^ 8'(i), 1'b0, '0, 1'b0, '0, "");
        for (int i = 0; i < 16; i++) drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'(i), "R11 ignored");

        // R5: reseed then read
        drive(1'b0, '0, '0, 1'b1, 6'd7, 1'b0, '0, "");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd7, "R5 reseed", 1'b1, 16'hFFFF);
        // R6: reseed and update on the same channel
        drive(1'b1, 6'd9, 8'h5A, 1'b0, '0, 1'b0, '0, "");
        drive(1'b1, 6'd9, 8'h3C, 1'b1, 6'd9, 1'b0, '0, "");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd9, "R6 init priority", 1'b1, 16'hFFFF);
        // R7: reseed and update on different channels
        drive(1'b1, 6'd10, 8'h11, 1'b0, '0, 1'b0, '0, "");
        drive(1'b1, 6'd11, 8'h22, 1'b1, 6'd10, 1'b0, '0, "");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd10, "R7 init side", 1'b1, 16'hFFFF);
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd11, "R7 update side");

        // R8: read and update the same channel together, pre-update value returned
        drive(1'b1, 6'd20, 8'h99, 1'b0, '0, 1'b1, 6'd20, "R8 same-cycle read");
        drive(1'b0, '0, '0, 1'b0, '0, 1'b1, 6'd20, "R8 post-update read");

        idle(4);
        done = 1'b1;
        check(exp_q.size() == 0, "R8 outstanding reads", 16'(exp_q.size()), 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule